// File: doc/BRIEF.md
# Load-Value Speculation Checkpoint Controller

This controller sits beside a simple in-order retirement stage. It lets a long-latency load retire before its memory data has come back. When the instruction at the head of the reorder buffer is a load that is still waiting for data, the controller does three things in the same cycle:

- It copies the architectural register image into a free checkpoint slot.
- It supplies a predicted value on a register write port.
- It grants retirement of the load, so the younger instructions behind it can drain.

Each early-retired load owns one checkpoint. The checkpoints are kept in a ring in age order.

When the memory response arrives, it carries the load's tag. The controller compares the returned value with the prediction it handed out. A correct prediction marks the checkpoint as confirmed, and confirmed checkpoints are released oldest first. A wrong prediction frees the failing checkpoint and every younger one. It presents the saved register image for one cycle together with a squash pulse, so the surrounding pipeline can restore state and discard later work.

Predictions come from a last-value table indexed by load address bits. Every response from an outstanding load trains the table with the real value.

Top module: `ldspec_ctrl`

## Requirements
- R1: `ld_retire` is high in a cycle only when `head_ld_pending` is high, fewer than NUM_CKPT checkpoints are held, `squash` is low, and no response in that cycle is mispredicting.
- R2: In the clock edge that ends a granted cycle, `arch_regs` is saved into the new checkpoint. During the squash cycle that belongs to that load, `restore_regs` shows exactly that saved image.
- R3: `pred_data` is the table entry selected by `head_pc[PC_LSB +: log2(PRED_DEPTH)]`, which is bits 7:2 by default. An entry that has never been written predicts zero. `pred_we` equals `ld_retire`, and `pred_dest` equals `head_dest`.
- R4: `occupancy` grows by one after each grant and never grows without one.
- R5: A response whose `resp_id` matches an outstanding, unconfirmed load and whose `resp_data` equals that load's prediction raises no squash.
- R6: A response whose `resp_data` differs from the prediction raises `squash` in the following cycle. It also frees that load's checkpoint and every younger one, so `occupancy` then equals the number of older checkpoints.
- R7: At most NUM_CKPT (4) checkpoints are held. When all are held, a pending load at the head is not granted.
- R8: `squash` lasts exactly one cycle, and `ld_retire` stays low during it.
- R9: A checkpoint is released only after its own load and every older load have been confirmed. Release happens from the oldest end, at one slot per cycle, starting the cycle after confirmation.
- R10: Every response from an outstanding load writes `resp_data` into the table entry of that load's address, whether the prediction matched or not. A response whose ID is not outstanding is ignored: no squash, no table write, and no change of occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_ld_pending | input | 1 | Head of reorder buffer is a load whose data is missing |
| head_pc | input | PC_W | Address of that load instruction |
| head_ld_id | input | ID_W | Tag of that load |
| head_dest | input | log2(NUM_REGS) | Destination register of that load |
| arch_regs | input | NUM_REGS*DATA_W | Current architectural register image |
| ld_retire | output | 1 | Early retirement granted for the head load |
| pred_we | output | 1 | Write enable of predicted value |
| pred_dest | output | log2(NUM_REGS) | Register written with predicted value |
| pred_data | output | DATA_W | Predicted load value |
| resp_valid | input | 1 | Memory response present |
| resp_id | input | ID_W | Tag of responding load |
| resp_data | input | DATA_W | Real load data |
| squash | output | 1 | One-cycle rollback pulse |
| restore_regs | output | NUM_REGS*DATA_W | Register image to restore during squash |
| occupancy | output | log2(NUM_CKPT+1) | Number of checkpoints held |

## Verification
The bench trains one load address through a sequence of matching and mismatching returns. This catches a table that is not updated on a mismatch, or that predicts garbage from an unwritten entry.

It fills all four slots and then checks that a fifth load stalls. A wrong full test would retire it and overwrite a live checkpoint.

It then mispredicts the third of four loads while a new load waits at the head. A design that truncated the ring at the wrong place, restored the wrong snapshot, or granted during the squash or mismatch cycle shows the wrong occupancy, the wrong restored image or a stray grant.

Finally, it confirms the younger survivor before the older one. It also sends a response with a stale tag. Releasing out of order, or acting on a dead tag, changes the occupancy or the trained value.

// File: rtl/ldspec_pkg.sv
package ldspec_pkg;
   // Distance of a ring slot from the oldest slot
   function automatic int unsigned ring_age(input int unsigned slot,
                                            input int unsigned oldest,
                                            input int unsigned depth);
      return (slot + depth - oldest) % depth;
   endfunction
endpackage

// File: rtl/ldspec_lvp.sv
// Last-value predictor: one value per address index, zero until first written.
module ldspec_lvp #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   parameter int PC_W   = 16,
   parameter int PC_LSB = 2,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   rd_pc,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] val_q [DEPTH];
   logic [DEPTH-1:0]  seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     seen_q <= '0;
      else if (wr_en) seen_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) val_q[wr_idx] <= wr_data;
   end

   assign rd_idx  = rd_pc[PC_LSB +: IDX_W];
   assign rd_data = seen_q[rd_idx] ? val_q[rd_idx] : '0;
endmodule

// File: rtl/ldspec_snap.sv
// Register-image snapshot slots, one per checkpoint.
module ldspec_snap #(
   parameter int NUM_CKPT = 4,
   parameter int IMG_W    = 128,
   localparam int PTR_W   = $clog2(NUM_CKPT)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_slot,
   input  logic [IMG_W-1:0] wr_img,
   input  logic [PTR_W-1:0] rd_slot,
   output logic [IMG_W-1:0] rd_img
);
   logic [IMG_W-1:0] img_q [NUM_CKPT];

   for (genvar s = 0; s < NUM_CKPT; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && wr_slot == PTR_W'(s)) img_q[s] <= wr_img;
      end
   end

   assign rd_img = img_q[rd_slot];
endmodule

// File: rtl/ldspec_track.sv
// Age-ordered ring of outstanding speculated loads.
module ldspec_track
   import ldspec_pkg::*;
#(
   parameter int NUM_CKPT = 4,
   parameter int ID_W     = 4,
   parameter int DATA_W   = 16,
   parameter int IDX_W    = 6,
   localparam int PTR_W   = $clog2(NUM_CKPT),
   localparam int CNT_W   = $clog2(NUM_CKPT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   input  logic [ID_W-1:0]   alloc_id,
   input  logic [DATA_W-1:0] alloc_pred,
   input  logic [IDX_W-1:0]  alloc_idx,
   input  logic              resp_valid,
   input  logic [ID_W-1:0]   resp_id,
   input  logic [DATA_W-1:0] resp_data,
   output logic              grant,
   output logic [PTR_W-1:0]  tail_slot,
   output logic              hit,
   output logic [PTR_W-1:0]  hit_slot,
   output logic [IDX_W-1:0]  hit_idx,
   output logic              mismatch,
   output logic [CNT_W-1:0]  occupancy
);
   logic [NUM_CKPT-1:0] live_q, ok_q;
   logic [ID_W-1:0]     tag_q  [NUM_CKPT];
   logic [DATA_W-1:0]   pred_q [NUM_CKPT];
   logic [IDX_W-1:0]    idx_q  [NUM_CKPT];
   logic [PTR_W-1:0]    head_q;
   logic [PTR_W-1:0]    age    [NUM_CKPT];
   logic                pop;

   always_comb begin
      hit       = 1'b0;
      hit_slot  = '0;
      occupancy = '0;
      for (int i = 0; i < NUM_CKPT; i++) begin
         age[i]    = PTR_W'(ring_age(i, int'(head_q), NUM_CKPT));
         occupancy = occupancy + CNT_W'(live_q[i]);
         if (!hit && resp_valid && live_q[i] && !ok_q[i] && tag_q[i] == resp_id) begin
            hit      = 1'b1;
            hit_slot = PTR_W'(i);
         end
      end
      hit_idx   = idx_q[hit_slot];
      mismatch  = hit && (resp_data != pred_q[hit_slot]);
      tail_slot = head_q + occupancy[PTR_W-1:0];
      grant     = alloc_req && (occupancy != CNT_W'(NUM_CKPT)) && !mismatch;
      pop       = live_q[head_q] && ok_q[head_q];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
         ok_q   <= '0;
         head_q <= '0;
      end else begin
         if (pop) begin
            live_q[head_q] <= 1'b0;
            ok_q[head_q]   <= 1'b0;
            head_q         <= head_q + 1'b1;
         end
         if (hit && !mismatch) ok_q[hit_slot] <= 1'b1;
         if (mismatch) begin
            for (int j = 0; j < NUM_CKPT; j++) begin
               if (age[j] >= age[hit_slot]) begin
                  live_q[j] <= 1'b0;
                  ok_q[j]   <= 1'b0;
               end
            end
         end
         if (grant) begin
            live_q[tail_slot] <= 1'b1;
            ok_q[tail_slot]   <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (grant) begin
         tag_q[tail_slot]  <= alloc_id;
         pred_q[tail_slot] <= alloc_pred;
         idx_q[tail_slot]  <= alloc_idx;
      end
   end
endmodule

// File: rtl/ldspec_ctrl.sv
module ldspec_ctrl #(
   parameter int NUM_REGS   = 8,
   parameter int DATA_W     = 16,
   parameter int NUM_CKPT   = 4,
   parameter int PRED_DEPTH = 64,
   parameter int PC_W       = 16,
   parameter int PC_LSB     = 2,
   parameter int ID_W       = 4,
   localparam int RIDX_W    = $clog2(NUM_REGS),
   localparam int IMG_W     = NUM_REGS * DATA_W,
   localparam int CNT_W     = $clog2(NUM_CKPT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_ld_pending,
   input  logic [PC_W-1:0]   head_pc,
   input  logic [ID_W-1:0]   head_ld_id,
   input  logic [RIDX_W-1:0] head_dest,
   input  logic [IMG_W-1:0]  arch_regs,
   output logic              ld_retire,
   output logic              pred_we,
   output logic [RIDX_W-1:0] pred_dest,
   output logic [DATA_W-1:0] pred_data,
   input  logic              resp_valid,
   input  logic [ID_W-1:0]   resp_id,
   input  logic [DATA_W-1:0] resp_data,
   output logic              squash,
   output logic [IMG_W-1:0]  restore_regs,
   output logic [CNT_W-1:0]  occupancy
);
   localparam int PTR_W = $clog2(NUM_CKPT);
   localparam int IDX_W = $clog2(PRED_DEPTH);

   if (NUM_CKPT < 2 || (NUM_CKPT & (NUM_CKPT - 1)) != 0) begin : g_bad_ckpt
      $error("NUM_CKPT must be a power of two of at least 2");
   end
   if ((PRED_DEPTH & (PRED_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("PRED_DEPTH must be a power of two");
   end
   if (PC_LSB + IDX_W > PC_W) begin : g_bad_pc
      $error("PC_W too narrow for predictor index");
   end

   logic              grant, hit, mismatch;
   logic [PTR_W-1:0]  tail_slot, hit_slot;
   logic [IDX_W-1:0]  rd_idx, hit_idx;
   logic [IMG_W-1:0]  snap_img;
   logic              squash_q;
   logic [IMG_W-1:0]  restore_q;

   ldspec_lvp #(.DATA_W(DATA_W), .DEPTH(PRED_DEPTH), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_lvp (
      .clk(clk), .rst_n(rst_n), .rd_pc(head_pc), .rd_idx(rd_idx), .rd_data(pred_data),
      .wr_en(hit), .wr_idx(hit_idx), .wr_data(resp_data));

   ldspec_track #(.NUM_CKPT(NUM_CKPT), .ID_W(ID_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .alloc_req(head_ld_pending && !squash_q),
      .alloc_id(head_ld_id), .alloc_pred(pred_data), .alloc_idx(rd_idx),
      .resp_valid(resp_valid), .resp_id(resp_id), .resp_data(resp_data),
      .grant(grant), .tail_slot(tail_slot), .hit(hit), .hit_slot(hit_slot),
      .hit_idx(hit_idx), .mismatch(mismatch), .occupancy(occupancy));

   ldspec_snap #(.NUM_CKPT(NUM_CKPT), .IMG_W(IMG_W)) u_snap (
      .clk(clk), .wr_en(grant), .wr_slot(tail_slot), .wr_img(arch_regs),
      .rd_slot(hit_slot), .rd_img(snap_img));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         squash_q  <= 1'b0;
         restore_q <= '0;
      end else begin
         squash_q <= mismatch;
         if (mismatch) restore_q <= snap_img;
      end
   end

   assign ld_retire    = grant;
   assign pred_we      = grant;
   assign pred_dest    = head_dest;
   assign squash       = squash_q;
   assign restore_regs = restore_q;
endmodule

// File: rtl/ldspec_ctrl_chk.sv
module ldspec_ctrl_chk #(
   parameter int NUM_CKPT = 4,
   localparam int CNT_W   = $clog2(NUM_CKPT + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             head_ld_pending,
   input logic             ld_retire,
   input logic             squash,
   input logic [CNT_W-1:0] occupancy
);
   assert_grant_needs_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ld_retire |-> head_ld_pending);
   assert_no_grant_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy == CNT_W'(NUM_CKPT)) |-> !ld_retire);
   assert_occ_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= CNT_W'(NUM_CKPT));
   assert_squash_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> !squash);
   assert_squash_blocks_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      squash |-> !ld_retire);
   assert_growth_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_retire |=> occupancy <= $past(occupancy));
endmodule

bind ldspec_ctrl ldspec_ctrl_chk #(.NUM_CKPT(NUM_CKPT)) u_chk (
   .clk(clk), .rst_n(rst_n), .head_ld_pending(head_ld_pending),
   .ld_retire(ld_retire), .squash(squash), .occupancy(occupancy));

// File: tb/sim_ldspec_ctrl.sv
module sim_ldspec_ctrl;
   localparam int NR = 8, DW = 16, IW = 4, PW = 16;
   localparam int IMG = NR * DW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic head_ld_pending = 1'b0;
   logic [PW-1:0] head_pc = '0;
   logic [IW-1:0] head_ld_id = '0;
   logic [2:0]    head_dest = '0;
   logic [IMG-1:0] arch_regs = '0;
   logic ld_retire, pred_we, squash;
   logic [2:0] pred_dest;
   logic [DW-1:0] pred_data;
   logic resp_valid = 1'b0;
   logic [IW-1:0] resp_id = '0;
   logic [DW-1:0] resp_data = '0;
   logic [IMG-1:0] restore_regs;
   logic [2:0] occupancy;

   int vec_cnt = 0, miss_cnt = 0;
   logic done = 1'b0;
   logic g_got;
   logic [DW-1:0] p_got;

   always #10 clk = ~clk;

   ldspec_ctrl u0 (.*);

   // {id, returned data, expected prediction, expected squash}
   localparam logic [36:0] VEC [6] = '{
      {4'd1, 16'h0000, 16'h0000, 1'b0},
      {4'd2, 16'h1234, 16'h0000, 1'b1},
      {4'd3, 16'h1234, 16'h1234, 1'b0},
      {4'd4, 16'hBEEF, 16'h1234, 1'b1},
      {4'd5, 16'hBEEF, 16'hBEEF, 1'b0},
      {4'd6, 16'h0007, 16'hBEEF, 1'b1}};

   function automatic logic [IMG-1:0] img_of(input logic [IW-1:0] id);
      return {NR{12'hA00, id}};
   endfunction

   task automatic check(input string req, input logic [IMG-1:0] got, input logic [IMG-1:0] exp);
      vec_cnt++;
      if (got !== exp) begin
         miss_cnt++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_load(input logic [IW-1:0] id, input logic [PW-1:0] pc, input logic [2:0] dst);
      head_ld_pending = 1'b1; head_ld_id = id; head_pc = pc; head_dest = dst;
      arch_regs = img_of(id);
      #1 g_got = ld_retire; p_got = pred_data;
      @(negedge clk);
      head_ld_pending = 1'b0;
   endtask

   task automatic do_resp(input logic [IW-1:0] id, input logic [DW-1:0] d);
      resp_valid = 1'b1; resp_id = id; resp_data = d;
      @(negedge clk);
      resp_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset squash", IMG'(squash), '0);
      check("R4 reset occupancy", IMG'(occupancy), '0);
      rst_n = 1'b1;
      #1 check("R1 idle no grant", IMG'(ld_retire), '0);
      @(negedge clk);

      // training vectors on one address
      for (int v = 0; v < 6; v++) begin
         do_load(VEC[v][36:33], 16'h0040, 3'd5);
         check("R1 grant", IMG'(g_got), IMG'(1));
         check("R3 prediction", IMG'(p_got), IMG'(VEC[v][16:1]));
         check("R4 occupancy after grant", IMG'(occupancy), IMG'(1));
         do_resp(VEC[v][36:33], VEC[v][32:17]);
         check(VEC[v][0] ? "R6 squash on mismatch" : "R5 no squash on match",
               IMG'(squash), IMG'(VEC[v][0]));
         if (VEC[v][0]) check("R2 restore image", restore_regs, img_of(VEC[v][36:33]));
         repeat (3) @(negedge clk);
         check("R9 slot released", IMG'(occupancy), '0);
      end

      // fill all slots
      for (int k = 8; k < 12; k++) do_load(IW'(k), 16'h0080, 3'd2);
      check("R7 four held", IMG'(occupancy), IMG'(4));
      head_ld_pending = 1'b1; head_ld_id = 4'd12;
      #1 check("R7 stall when full", IMG'(ld_retire), '0);
      // mispredict third load while one waits
      resp_valid = 1'b1; resp_id = 4'd10; resp_data = 16'h0077;
      #1 check("R3 pred_we follows grant", IMG'(pred_we), '0);
      @(negedge clk);
      resp_valid = 1'b0;
      #1 check("R8 grant held in squash", IMG'(ld_retire), '0);
      check("R6 squash raised", IMG'(squash), IMG'(1));
      check("R2 restore of third", restore_regs, img_of(4'd10));
      check("R6 truncated occupancy", IMG'(occupancy), IMG'(2));
      head_ld_pending = 1'b0;
      @(negedge clk);
      check("R8 squash one cycle", IMG'(squash), '0);

      // stale tag ignored
      do_resp(4'd10, 16'h0099);
      check("R10 stale no squash", IMG'(squash), '0);
      check("R10 stale occupancy", IMG'(occupancy), IMG'(2));
      head_ld_pending = 1'b1; head_pc = 16'h0080; head_dest = 3'd6;
      #1 check("R10 table trained by mismatch only", IMG'(pred_data), IMG'(16'h0077));
      check("R3 dest passthrough", IMG'(pred_dest), IMG'(6));
      #1 head_ld_pending = 1'b0;
      @(negedge clk);

      // younger confirmed first
      do_resp(4'd9, 16'h0000);
      repeat (3) @(negedge clk);
      check("R9 younger waits for older", IMG'(occupancy), IMG'(2));
      do_resp(4'd8, 16'h0000);
      repeat (4) @(negedge clk);
      check("R9 both released", IMG'(occupancy), '0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            miss_cnt++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
      $finish;
   end
endmodule